// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block keeps the protection state of a serial memory device: a hardware-protect enable bit, a two-bit block-protect level, the write-enable latch and a busy indication. It produces the status byte that a status read shifts out. It also produces two permit signals. One says whether the array address on the query input may be programmed. The other says whether a status register write may be accepted now.

The command decoder drives single-cycle strobes for write-enable, write-disable and write-status. A write-status strobe carries the byte that was received. An accepted status write is held as pending until chip select deasserts. It then becomes committed, and the unit raises a one-cycle start pulse for the write engine. The engine reports its internal cycle on the busy input. The nonvolatile bits are modelled as flops, and they take the committed value only when busy falls.

All pins are plain control and status pins. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `srwp_unit`

## Requirements
- R1: When busy is low, status_byte is {wpen, 3'b000, bp[1], bp[0], wel, 1'b0}: bit 7 is the protect enable, bits 6..4 are zero, bits 3..2 are the block-protect level, bit 1 is the write-enable latch and bit 0 is busy.
- R2: While busy is high, status_byte reads 8'hFF.
- R3: The block-protect level selects the protected range of the 17-bit array. 2'b00 protects nothing. 2'b01 protects 18000h..1FFFFh. 2'b10 protects 10000h..1FFFFh. 2'b11 protects every address.
- R4: arr_wr_ok is high exactly when the latch is set, busy is low and qaddr lies outside the protected range. This holds whatever the WP pin and the enable bit are.
- R5: sr_wr_ok is high exactly when the latch is set, busy is low and hardware protection is off. Hardware protection is on when wp_n is low and the enable bit is one. A write that would clear the enable bit is refused the same way.
- R6: The latch is clear after reset. A write-enable strobe sets it and a write-disable strobe clears it from the next cycle; write-disable wins, and wp_n has no effect on either. The latch clears in the cycle after busy falls. Strobes that arrive while busy is high are ignored.
- R7: A write-status strobe with sr_wr_ok high and cs_n low is staged. In the first cycle with cs_n high, sr_go pulses for one cycle. When busy later falls, only bits 7, 3 and 2 of the staged byte are loaded.
- R8: A staged write is dropped if wp_n is low while cs_n is still low and the enable bit is one. Once sr_go has pulsed, wp_n no longer affects the write.
- R9: The enable and block-protect bits change only in the cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, low while a command is in progress |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal write cycle running |
| wren_stb | input | 1 | Write-enable command strobe |
| wrdi_stb | input | 1 | Write-disable command strobe |
| wrsr_stb | input | 1 | Write-status command strobe |
| wrsr_data | input | 8 | Byte received with write-status |
| qaddr | input | 17 | Array address to be checked |
| status_byte | output | 8 | Status byte for reads |
| arr_wr_ok | output | 1 | Array write permitted at qaddr |
| sr_wr_ok | output | 1 | Status write permitted now |
| sr_go | output | 1 | One-cycle start request for a committed status write |

## Verification
Array permission is checked at the addresses on each side of the quarter and half boundaries, and at the lowest and highest address, under every protection level. This separates an off-by-one range from a wrong level decode. Status writes are driven in four cases: WP high, WP low with the enable bit set, WP low with the enable bit clear, and WP falling before and after the commit pulse. These cases separate the hardware-protection rule from the cancel window. Written bytes set the unused and latch positions to one to show that they are masked. Commands issued during busy show that they are ignored and that the status reads all ones.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

  // fields of the status register that survive power loss
  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } nvbits_t;

  // positions in the status byte
  localparam int SB_WPEN  = 7;
  localparam int SB_BP_HI = 3;
  localparam int SB_BP_LO = 2;
  localparam int SB_WEL   = 1;
  localparam int SB_BUSY  = 0;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_lvl_e;

  function automatic nvbits_t extract_nv(input logic [7:0] b);
    nvbits_t n;
    n.wpen = b[SB_WPEN];
    n.bp   = b[SB_BP_HI:SB_BP_LO];
    return n;
  endfunction

endpackage

// File: rtl/srwp_region.sv
module srwp_region #(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        lvl,
  output logic              hit
);
  import srwp_pkg::*;

  localparam int TOP = ADDR_W - 1;

  logic qtr_hit, half_hit;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign qtr_hit  = addr[TOP] & addr[TOP-1];
      assign half_hit = addr[TOP];
    end else begin : g_narrow
      assign qtr_hit  = addr[TOP];
      assign half_hit = addr[TOP];
    end
  endgenerate

  always_comb begin
    case (prot_lvl_e'(lvl))
      PROT_NONE: hit = 1'b0;
      PROT_QTR:  hit = qtr_hit;
      PROT_HALF: hit = half_hit;
      default:   hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/srwp_wel.sv
module srwp_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic busy_fall,
  input  logic set_stb,
  input  logic clr_stb,
  output logic wel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wel <= 1'b0;
    else if (busy_fall)        wel <= 1'b0;
    else if (!busy && clr_stb) wel <= 1'b0;
    else if (!busy && set_stb) wel <= 1'b1;
  end

  // R6
  wel_end_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_fall |=> !wel);

  // R6
  wel_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !busy_fall) |=> $stable(wel));

  // R6
  wel_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !busy) |=> !wel);
endmodule

// File: rtl/srwp_stage.sv
module srwp_stage (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wp_n,
  input  logic             busy_fall,
  input  logic             take,
  input  logic [7:0]       wdata,
  output srwp_pkg::nvbits_t nv,
  output logic             go
);
  import srwp_pkg::*;

  logic    pend, com;
  nvbits_t pd, cd;
  logic    cancel;

  assign cancel = pend & ~cs_n & ~wp_n & nv.wpen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      pd   <= '0;
      com  <= 1'b0;
      cd   <= '0;
      go   <= 1'b0;
      nv   <= '0;
    end else begin
      go <= 1'b0;
      if (cancel) begin
        pend <= 1'b0;
      end else if (pend && cs_n) begin
        pend <= 1'b0;
        com  <= 1'b1;
        cd   <= pd;
        go   <= 1'b1;
      end else if (take) begin
        pend <= 1'b1;
        pd   <= extract_nv(wdata);
      end
      if (busy_fall && com) begin
        nv  <= cd;
        com <= 1'b0;
      end
    end
  end

  // R8
  stage_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !cs_n && !wp_n && nv.wpen) |=> (!pend && !go));

  // R7
  stage_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ($past(pend) && $past(cs_n)));

  // R7
  stage_go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);

  // R9
  stage_nv_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nv) |-> $past(busy_fall));
endmodule

// File: rtl/srwp_unit.sv
module srwp_unit #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              wren_stb,
  input  logic              wrdi_stb,
  input  logic              wrsr_stb,
  input  logic [7:0]        wrsr_data,
  input  logic [ADDR_W-1:0] qaddr,
  output logic [7:0]        status_byte,
  output logic              arr_wr_ok,
  output logic              sr_wr_ok,
  output logic              sr_go
);
  import srwp_pkg::*;

  logic    busy_q, busy_fall;
  logic    wel, hit, hw_prot, take;
  nvbits_t nv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy;
  end
  assign busy_fall = busy_q & ~busy;

  srwp_wel u_wel (
    .clk(clk), .rst_n(rst_n), .busy(busy), .busy_fall(busy_fall),
    .set_stb(wren_stb), .clr_stb(wrdi_stb), .wel(wel)
  );

  srwp_region #(.ADDR_W(ADDR_W)) u_region (
    .addr(qaddr), .lvl(nv.bp), .hit(hit)
  );

  assign hw_prot   = ~wp_n & nv.wpen;
  assign sr_wr_ok  = wel & ~busy & ~hw_prot;
  assign arr_wr_ok = wel & ~busy & ~hit;
  assign take      = wrsr_stb & sr_wr_ok & ~cs_n;

  srwp_stage u_stage (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .busy_fall(busy_fall), .take(take), .wdata(wrsr_data),
    .nv(nv), .go(sr_go)
  );

  always_comb begin
    if (busy) begin
      status_byte = 8'hFF;
    end else begin
      status_byte           = '0;
      status_byte[SB_WPEN]  = nv.wpen;
      status_byte[SB_BP_HI] = nv.bp[1];
      status_byte[SB_BP_LO] = nv.bp[0];
      status_byte[SB_WEL]   = wel;
      status_byte[SB_BUSY]  = 1'b0;
    end
  end

  // R5
  sr_hw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_ok |-> !(!wp_n && status_byte[SB_WPEN]));

  // R4
  arr_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok |-> (status_byte[SB_WEL] && !busy));

  // R2
  busy_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!arr_wr_ok && !sr_wr_ok && &status_byte));
endmodule

// File: tb/sim_srwp_unit.sv
module sim_srwp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wp_n = 1'b1, busy = 1'b0;
  logic        wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [16:0] qaddr = '0;
  logic [7:0]  status_byte;
  logic        arr_wr_ok, sr_wr_ok, sr_go;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srwp_unit u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .busy(busy),
    .wren_stb(wren), .wrdi_stb(wrdi), .wrsr_stb(wrsr), .wrsr_data(wdata),
    .qaddr(qaddr), .status_byte(status_byte), .arr_wr_ok(arr_wr_ok),
    .sr_wr_ok(sr_wr_ok), .sr_go(sr_go)
  );

  // behavioural reference state
  int m_wel, m_wpen, m_bp, m_pend, m_pw, m_pb, m_com, m_cw, m_cb, m_go, m_prevbusy;

  function automatic int m_prot(int a, int lvl);
    if (lvl == 0) return 0;
    if (lvl == 1) return (a >= 'h18000) ? 1 : 0;
    if (lvl == 2) return (a >= 'h10000) ? 1 : 0;
    return 1;
  endfunction

  function automatic int m_srok();
    if (m_wel == 0 || busy) return 0;
    if (!wp_n && m_wpen == 1) return 0;
    return 1;
  endfunction

  function automatic int m_arrok();
    if (m_wel == 0 || busy) return 0;
    return m_prot(int'(qaddr), m_bp) ? 0 : 1;
  endfunction

  function automatic int m_status();
    if (busy) return 255;
    return m_wpen * 128 + m_bp * 4 + m_wel * 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wel = 0; m_wpen = 0; m_bp = 0; m_pend = 0; m_pw = 0; m_pb = 0;
      m_com = 0; m_cw = 0; m_cb = 0; m_go = 0; m_prevbusy = 0;
    end else begin
      int srok_now;
      int ended;
      srok_now = m_srok();
      ended = (m_prevbusy == 1 && !busy) ? 1 : 0;
      m_go = 0;
      if (m_pend == 1 && !cs_n && !wp_n && m_wpen == 1) m_pend = 0;
      else if (m_pend == 1 && cs_n) begin
        m_pend = 0; m_com = 1; m_cw = m_pw; m_cb = m_pb; m_go = 1;
      end else if (wrsr && !cs_n && srok_now == 1) begin
        m_pend = 1; m_pw = wdata[7]; m_pb = wdata[3:2];
      end
      if (ended == 1) begin
        m_wel = 0;
        if (m_com == 1) begin m_wpen = m_cw; m_bp = m_cb; m_com = 0; end
      end else if (!busy) begin
        if (wrdi) m_wel = 0;
        else if (wren) m_wel = 1;
      end
      m_prevbusy = busy ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(int'(status_byte) == m_status(), "R1/R2 status_byte", status_byte, m_status());
      chk(int'(arr_wr_ok) == m_arrok(), "R3/R4 arr_wr_ok", arr_wr_ok, m_arrok());
      chk(int'(sr_wr_ok) == m_srok(), "R5 sr_wr_ok", sr_wr_ok, m_srok());
      chk(int'(sr_go) == m_go, "R7/R8 sr_go", sr_go, m_go);
    end
    if (cyc > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic strobe(input int kind, input logic [7:0] d);
    cs_n = 1'b0;
    wren = (kind == 0); wrdi = (kind == 1); wrsr = (kind == 2); wdata = d;
    step(1);
    wren = 0; wrdi = 0; wrsr = 0;
  endtask

  task automatic end_cmd();
    cs_n = 1'b1;
    step(2);
  endtask

  task automatic run_busy(input int n);
    busy = 1'b1;
    step(n);
    busy = 1'b0;
    step(2);
  endtask

  task automatic sweep_addrs();
    int al[6] = '{'h00000, 'h0FFFF, 'h10000, 'h17FFF, 'h18000, 'h1FFFF};
    foreach (al[i]) begin
      qaddr = al[i][16:0];
      step(1);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R6 reset state: latch clear, status zero
    chk(status_byte == 8'h00, "R6 reset status", status_byte, 0);
    sweep_addrs();                        // R4 nothing writable without latch
    strobe(0, 8'h00); end_cmd();          // R6 set latch
    chk(status_byte[1] == 1'b1, "R6 latch set", status_byte, 2);
    sweep_addrs();                        // R3 level 00
    // R7 write with noise in masked bits: F7 -> wpen=1 bp=01
    strobe(2, 8'hF7);
    step(2);
    end_cmd();
    run_busy(5);                          // R2 all ones, R9 load on fall
    chk(status_byte == 8'h84, "R7 loaded bits only", status_byte, 'h84);
    sweep_addrs();                        // R4 latch cleared by cycle end
    strobe(0, 8'h00); end_cmd();
    sweep_addrs();                        // R3 level 01
    // R5 hardware protection: cannot clear wpen
    wp_n = 1'b0; step(1);
    strobe(2, 8'h00); end_cmd();
    chk(status_byte == 8'h86, "R5 refused under WP", status_byte, 'h86);
    sweep_addrs();                        // R4 unprotected still writable
    // R6 write-disable works with WP low
    strobe(1, 8'h00); end_cmd();
    chk(status_byte == 8'h84, "R6 disable with WP low", status_byte, 'h84);
    // R8 cancel: WP falls while cs_n low
    wp_n = 1'b1; step(1);
    strobe(0, 8'h00); end_cmd();
    strobe(2, 8'h88);
    wp_n = 1'b0; step(2);
    end_cmd();
    chk(status_byte == 8'h86, "R8 cancelled", status_byte, 'h86);
    // R8 after commit WP has no effect
    wp_n = 1'b1; step(1);
    strobe(2, 8'h08);
    end_cmd();
    wp_n = 1'b0;
    run_busy(4);
    chk(status_byte == 8'h08, "R8 committed write kept", status_byte, 'h08);
    // R5 wpen clear: WP low is ignored
    strobe(0, 8'h00); end_cmd();
    sweep_addrs();                        // R3 level 10
    strobe(2, 8'h0C); end_cmd();
    run_busy(3);
    chk(status_byte == 8'h0C, "R5 write with WP low and wpen 0", status_byte, 'h0C);
    // R6 commands ignored while busy
    busy = 1'b1; step(1);
    strobe(0, 8'h00); strobe(2, 8'h00); cs_n = 1'b1;
    step(2);
    busy = 1'b0; step(2);
    chk(status_byte == 8'h0C, "R6 ignored during busy", status_byte, 'h0C);
    sweep_addrs();                        // R3 level 11
    wp_n = 1'b1;
    step(2);
    finish_run();
  end
endmodule